// File: doc/BRIEF.md
# Thresholded Interrupt Enable and Status Unit

This unit collects six event sources of a USB 2.0 host controller into one level-sensitive interrupt line. Each event sets a sticky status bit. A separate 32-bit enable register decides which status bits may reach the interrupt line. Software writes the enable register and acknowledges events over a small read/write register port. It clears a status bit by writing a 1 to its position.

The six sources fall into two groups. Port change, frame list rollover and host system error reach the interrupt line at once. Transfer completion, transfer error and asynchronous advance are held back. They count only after the next interrupt-threshold tick. That tick comes from a counter of micro-frame pulses with a selectable period of 1, 2, 4, 8, 16, 32 or 64 micro-frames. A source whose enable bit is 0 still records its status bit, so software can poll for it.

Top module: `irq_thresh_unit`

## Requirements
- R1: After reset the enable register, every status bit and `irq_o` are 0, and both registers read as 0.
- R2: A write with `bus_addr_i`=0 loads enable bits 5:0 from `bus_wdata_i[5:0]`. Bits 31:6 of both registers always read as 0, whatever was written.
- R3: Source positions are the same in the event input, the status register and the enable register: bit 0 transfer complete, bit 1 transfer error, bit 2 port change, bit 3 frame list rollover, bit 4 host system error, bit 5 async advance.
- R4: A 1 on `evt_i[i]` for one cycle sets status bit i at the next edge. The bit sets whether or not enable bit i is 1, and it stays set until it is cleared.
- R5: A write with `bus_addr_i`=1 clears every status bit whose `bus_wdata_i` bit is 1 and leaves the others unchanged. If an event arrives for a bit in the same cycle as its clear, the bit stays set.
- R6: For bits 2, 3 and 4, `irq_o` is 1 in the cycle after the status bit and the enable bit are both 1. No threshold tick is needed.
- R7: Bits 0, 1 and 5 affect `irq_o` only after a threshold tick that occurs while the status bit is already set. An event that arrives in the same cycle as a tick waits for the following tick. The `irq_o` line rises one cycle after the qualifying tick.
- R8: A threshold tick occurs on every 2^s-th `uframe_tick_i` pulse, where s is `thr_sel_i` and the count starts from reset. Values of s above 6 act as 6.
- R9: `irq_o` falls one cycle after the last enabled, visible status bit is cleared, or one cycle after its enable bit is written to 0.
- R10: `bus_rdata_o` shows the register selected by `bus_addr_i` (0 = enable, 1 = status) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | One-cycle event pulses, one bit per source |
| uframe_tick_i | input | 1 | One pulse per micro-frame |
| thr_sel_i | input | 3 | Threshold period as log2 of micro-frames |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 enable, 1 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Two pairs of events can land in the same cycle. An event can arrive in the cycle that software clears the same status bit. An event on a delayed source can also arrive in the cycle of a threshold tick. The bench drives the event together with the status-clearing write and then reads the status register back. It must read 1, because the event wins. The bench also pulses an event together with a micro-frame tick while the threshold period is one micro-frame. The interrupt must stay low until the next tick.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;
    localparam int NSRC     = 6;
    localparam int REG_W    = 32;
    localparam int MAX_LOG2 = 6;
    localparam int SEL_W    = 3;
    // sources that wait for a threshold tick: transfer, error, async advance
    localparam logic [NSRC-1:0] GATED_MASK = 6'b100011;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_thr_timer.sv
module irq_thr_timer
    import irq_thr_pkg::*;
#(
    parameter int MAXL = MAX_LOG2,
    parameter int SW   = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uframe_tick_i,
    input  logic [SW-1:0] sel_i,
    output logic          thr_tick_o
);
    localparam int CNT_W = (MAXL < 1) ? 1 : MAXL;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic [SW-1:0]    eff_sel;
    logic [CNT_W-1:0] last_cnt;
    logic             fire;

    always_comb begin
        if (int'(sel_i) > MAXL) eff_sel = SW'(MAXL);
        else                    eff_sel = sel_i;
        last_cnt = CNT_W'((32'd1 << eff_sel) - 32'd1);
        fire     = uframe_tick_i && (st_q.cnt >= last_cnt);
        st_d     = st_q;
        if (fire)               st_d.cnt = '0;
        else if (uframe_tick_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr_tick_o = fire;
endmodule

// File: rtl/irq_thr_status.sv
module irq_thr_status
    import irq_thr_pkg::*;
#(
    parameter int            N    = NSRC,
    parameter logic [N-1:0]  GMSK = GATED_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic         thr_tick_i,
    output logic [N-1:0] sts_o,
    output logic [N-1:0] vis_o,
    output logic [N-1:0] eff_o
);
    typedef struct packed {
        logic [N-1:0] sts;
        logic [N-1:0] vis;
    } sts_st_t;

    sts_st_t st_d, st_q;

    always_comb begin
        st_d.sts = (st_q.sts & ~clr_i) | evt_i;
        // gated bits copy the settled status on a tick, and drop with it
        st_d.vis = (thr_tick_i ? st_q.sts : st_q.vis) & st_d.sts & GMSK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        if (GMSK[g]) begin : g_gated
            assign eff_o[g] = st_q.vis[g];
        end else begin : g_direct
            assign eff_o[g] = st_q.sts[g];
        end
    end

    assign sts_o = st_q.sts;
    assign vis_o = st_q.vis;
endmodule

// File: rtl/irq_thresh_unit.sv
module irq_thresh_unit
    import irq_thr_pkg::*;
#(
    parameter int               RW   = REG_W,
    parameter int               N    = NSRC,
    parameter int               MAXL = MAX_LOG2,
    parameter int               SW   = SEL_W,
    parameter logic [N-1:0]     GMSK = GATED_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_i,
    input  logic          uframe_tick_i,
    input  logic [SW-1:0] thr_sel_i,
    input  logic          bus_wr_i,
    input  logic          bus_addr_i,
    input  logic [RW-1:0] bus_wdata_i,
    output logic [RW-1:0] bus_rdata_o,
    output logic          irq_o
);
    localparam int PAD_W = RW - N;

    typedef struct packed {
        logic [N-1:0] en;
        logic         irq;
    } top_st_t;

    top_st_t      st_d, st_q;
    logic [N-1:0] en_q, sts_q, vis_q, eff, clr;
    logic         thr_tick;
    logic         sel_status;
    logic         unused_wdata_hi;

    assign sel_status      = (reg_sel_e'(bus_addr_i) == REG_STATUS);
    assign unused_wdata_hi = ^bus_wdata_i[RW-1:N];
    assign clr             = (bus_wr_i && sel_status) ? bus_wdata_i[N-1:0] : '0;

    irq_thr_timer #(.MAXL(MAXL), .SW(SW)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .uframe_tick_i (uframe_tick_i),
        .sel_i         (thr_sel_i),
        .thr_tick_o    (thr_tick)
    );

    irq_thr_status #(.N(N), .GMSK(GMSK)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_i      (clr),
        .thr_tick_i (thr_tick),
        .sts_o      (sts_q),
        .vis_o      (vis_q),
        .eff_o      (eff)
    );

    always_comb begin
        st_d     = st_q;
        if (bus_wr_i && !sel_status) st_d.en = bus_wdata_i[N-1:0];
        st_d.irq = |(st_q.en & eff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q        = st_q.en;
    assign irq_o       = st_q.irq;
    assign bus_rdata_o = {{PAD_W{1'b0}}, (sel_status ? sts_q : en_q)};
endmodule

// File: rtl/irq_thresh_unit_chk.sv
module irq_thresh_unit_chk #(
    parameter int           RW   = 32,
    parameter int           N    = 6,
    parameter logic [N-1:0] GMSK = 6'b100011
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  evt_i,
    input logic          bus_wr_i,
    input logic          bus_addr_i,
    input logic [RW-1:0] bus_wdata_i,
    input logic [RW-1:0] bus_rdata_o,
    input logic          irq_o,
    input logic [N-1:0]  en_q,
    input logic [N-1:0]  sts_q,
    input logic [N-1:0]  vis_q,
    input logic          thr_tick
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_o[RW-1:N] == '0);

    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i) |=> ((sts_q & $past(bus_wdata_i[N-1:0] & ~evt_i)) == '0));

    a_r6_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_q & sts_q & ~GMSK)) |=> irq_o);

    a_r7_wait_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_tick |=> ((vis_q & ~$past(vis_q)) == '0));

    a_r9_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_o);
endmodule

bind irq_thresh_unit irq_thresh_unit_chk #(.RW(RW), .N(N), .GMSK(GMSK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .en_q        (en_q),
    .sts_q       (sts_q),
    .vis_q       (vis_q),
    .thr_tick    (thr_tick)
);

// File: tb/irq_thresh_unit_test.sv
module irq_thresh_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt = '0;
    logic        uf = 1'b0;
    logic [2:0]  sel = '0;
    logic        wr = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          errors = 0;
    int          checks = 0;

    always #10 clk = ~clk;

    irq_thresh_unit uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .uframe_tick_i(uf),
        .thr_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] s);
        rst_n = 1'b0; evt = '0; uf = 1'b0; wr = 1'b0; sel = s;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        cyc();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_evt(input logic [5:0] v);
        evt = v;
        cyc();
        evt = '0;
    endtask

    task automatic pulse_uf();
        uf = 1'b1;
        cyc();
        uf = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bit          imm;
        cyc();
        do_reset(3'd0);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
        rd_reg(1'b0, d); chk(d == 32'd0, "R1 enable after reset", d, 32'd0);
        rd_reg(1'b1, d); chk(d == 32'd0, "R1 status after reset", d, 32'd0);

        // R2/R10 reserved bits ignored
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd_reg(1'b0, d); chk(d == 32'h3F, "R2 enable readback", d, 32'h3F);
        wr_reg(1'b0, 32'hA5A5_A512);
        rd_reg(1'b0, d); chk(d == 32'h12, "R2 enable partial", d, 32'h12);
        rd_reg(1'b1, d); chk(d == 32'h0, "R10 status selected", d, 32'h0);

        // sweep every source with enable off and on: R3 R4 R6 R7 R9
        for (int i = 0; i < 6; i++) begin
            for (int en = 0; en < 2; en++) begin
                imm = (i >= 2 && i <= 4);
                do_reset(3'd0);
                if (en == 1) wr_reg(1'b0, 32'd1 << i);
                pulse_evt(6'd1 << i);
                rd_reg(1'b1, d);
                chk(d == (32'd1 << i), "R3/R4 status bit set", d, 32'd1 << i);
                cyc();
                chk(irq == (en == 1 && imm), "R6/R7 irq before tick", {31'd0, irq}, {31'd0, (en == 1 && imm)});
                cyc();
                chk(irq == (en == 1 && imm), "R7 irq held without tick", {31'd0, irq}, {31'd0, (en == 1 && imm)});
                pulse_uf();
                cyc();
                chk(irq == (en == 1), "R7 irq after tick", {31'd0, irq}, {31'd0, (en == 1)});
                wr_reg(1'b1, 32'd1 << i);
                chk(irq == (en == 1), "R9 irq still up at clear edge", {31'd0, irq}, {31'd0, (en == 1)});
                cyc();
                chk(irq == 1'b0, "R9 irq dropped after clear", {31'd0, irq}, 32'd0);
                rd_reg(1'b1, d);
                chk(d == 32'd0, "R5 status cleared", d, 32'd0);
            end
        end

        // R5 selective clear, write of zero, event beats clear
        do_reset(3'd0);
        pulse_evt(6'h3F);
        wr_reg(1'b1, 32'h0000_0005);
        rd_reg(1'b1, d); chk(d == 32'h3A, "R5 selective clear", d, 32'h3A);
        wr_reg(1'b1, 32'h0);
        rd_reg(1'b1, d); chk(d == 32'h3A, "R5 zero write keeps", d, 32'h3A);
        evt = 6'h02; wr = 1'b1; addr = 1'b1; wdata = 32'h02;
        cyc();
        evt = '0; wr = 1'b0; wdata = '0;
        rd_reg(1'b1, d); chk(d == 32'h3A, "R5 event wins over clear", d, 32'h3A);

        // R7 event in the same cycle as a tick waits for the next tick
        do_reset(3'd0);
        wr_reg(1'b0, 32'h1);
        evt = 6'h01; uf = 1'b1;
        cyc();
        evt = '0; uf = 1'b0;
        cyc(); cyc();
        chk(irq == 1'b0, "R7 same-cycle tick not taken", {31'd0, irq}, 32'd0);
        pulse_uf();
        cyc();
        chk(irq == 1'b1, "R7 next tick taken", {31'd0, irq}, 32'd1);

        // R9 enable drop removes irq
        do_reset(3'd0);
        wr_reg(1'b0, 32'h10);
        pulse_evt(6'h10);
        cyc();
        chk(irq == 1'b1, "R6 host error immediate", {31'd0, irq}, 32'd1);
        wr_reg(1'b0, 32'h0);
        chk(irq == 1'b1, "R9 irq at enable-off edge", {31'd0, irq}, 32'd1);
        cyc();
        chk(irq == 1'b0, "R9 irq off after disable", {31'd0, irq}, 32'd0);

        // R8 threshold period sweep, including the clamped setting
        for (int s = 0; s < 8; s++) begin
            int n;
            n = 1 << ((s > 6) ? 6 : s);
            do_reset(3'(s));
            wr_reg(1'b0, 32'h1);
            pulse_evt(6'h01);
            if (n > 1) begin
                uf = 1'b1;
                repeat (n - 1) cyc();
                uf = 1'b0;
                cyc(); cyc();
                chk(irq == 1'b0, "R8 no tick before period", {31'd0, irq}, 32'd0);
            end
            pulse_uf();
            cyc();
            chk(irq == 1'b1, "R8 tick at period", {31'd0, irq}, 32'd1);
        end

        finish_run();
    end
endmodule